// File: doc/BRIEF.md
# Accumulator and Device Port Execution Unit

This unit carries out the non-memory instructions of a small accumulator machine in a single timing step. When the sequencer reaches the execute step of an instruction whose decoded class is "register or device", it raises `exec_en` for one cycle. It also presents the group select (`io_group` low for accumulator/link operations, high for device operations) and the 12 low instruction bits. Each instruction bit selects one operation, and several bits may be set together. The accumulator, link bit and program counter live outside the unit. The unit returns the new accumulator and link values with write enables, and gives a one-cycle `pc_inc` pulse when a skip condition holds. In the same cycle it pulses `sc_clr` so the sequencer restarts its step count.

The unit owns the device-side state. This is an 8-bit input buffer with its ready flag, an 8-bit output buffer with its ready flag, the interrupt enable and the run state. A device loads the input buffer and raises the input-ready flag with `dev_in_stb`, and it signals that it has consumed output with `dev_out_ack`. The run state is a two-state machine. `ST_RUN` is entered on reset. The transition `T_STOP` (a register-group step with the stop bit set) moves it to `ST_HALT`. `ST_HALT` then holds until reset (`T_HOLD`), and while halted every execute request is ignored.

Top module: `accum_io_exec`

## Requirements
- R1: Every executed step (`exec_en` high while running) pulses `sc_clr` in that same cycle, in both groups.
- R2: Register group single bits: bit 11 clears the accumulator, bit 10 clears the link, bit 9 inverts the accumulator, bit 8 inverts the link, bit 5 adds one to the accumulator (link unchanged). `ac_we` is high when any of bits 11,9,7,6,5 is set, and `e_we` is high when any of bits 10,8,7,6 is set.
- R3: Register group bit 7 rotates right through the link: the new accumulator is {link, acc[15:1]} and the new link is acc[0]. Bit 6 rotates left: the new accumulator is {acc[14:0], link} and the new link is acc[15].
- R4: When several register bits are set, the operations compose in the order: clear acc, clear link, invert acc, invert link, rotate right, rotate left, increment.
- R5: Register skip bits test the values before the step: bit 4 acc[15]==0, bit 3 acc[15]==1, bit 2 acc==0, bit 1 link==0. Any true condition gives exactly one `pc_inc` pulse in the step cycle.
- R6: Register bit 0 moves the run state to halted from the next cycle. While halted, `exec_en` produces no `sc_clr`, `ac_we`, `e_we` or `pc_inc`, and it changes no device state. Only reset leaves the halted state.
- R7: Device bit 11 puts the input buffer (as held before the step) into acc[7:0], keeps acc[15:8], raises `ac_we`, and clears the input-ready flag at the clock edge.
- R8: Device bit 10 copies the pre-step acc[7:0] into the output buffer and clears the output-ready flag at the clock edge. With bits 11 and 10 together, the output takes the old accumulator.
- R9: Device bit 9 skips when input-ready is 1, and bit 8 skips when output-ready is 1. Both use the flags before the step.
- R10: Device bit 7 sets the interrupt enable and bit 6 clears it. With both set, the enable ends cleared.
- R11: `dev_in_stb` loads `dev_in_data` into the input buffer and sets input-ready. `dev_out_ack` sets output-ready. A strobe or acknowledge in the same cycle as a clearing step leaves the flag set.
- R12: After reset the unit is running, both ready flags and the interrupt enable are 0, and the output buffer reads 0.
- R13: With all 12 bits zero, or with `exec_en` low, the accumulator and link pass through unchanged, with no write enable and no `pc_inc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| exec_en | input | 1 | Execute step strobe for this instruction class |
| io_group | input | 1 | 0 = accumulator/link group, 1 = device group |
| ir_bits | input | 12 | One-hot-per-operation instruction bits |
| ac_in | input | DATA_W | Current accumulator |
| e_in | input | 1 | Current link bit |
| dev_in_data | input | IO_W | Device input byte |
| dev_in_stb | input | 1 | Device input strobe |
| dev_out_ack | input | 1 | Device output acknowledge |
| ac_out | output | DATA_W | New accumulator value |
| ac_we | output | 1 | Accumulator write enable |
| e_out | output | 1 | New link value |
| e_we | output | 1 | Link write enable |
| pc_inc | output | 1 | Skip: advance program counter once |
| sc_clr | output | 1 | Clear step counter |
| out_data | output | IO_W | Output buffer |
| in_ready | output | 1 | Input-ready flag |
| out_ready | output | 1 | Output-ready flag |
| int_en | output | 1 | Interrupt enable |
| running | output | 1 | Run state is ST_RUN |

## Verification
The bench sweeps all 2048 combinations of register bits 11..1 against accumulator values at the sign, zero and carry boundaries, with both link values. A wrong composition order or a skip tested on the post-step value shows up as a wrong accumulator, link or skip pulse on some combination. Directed device sequences go after the races. A clear that beats a same-cycle strobe leaves input-ready low. An output buffer fed from the freshly read accumulator shows the input byte instead of the old one. A design that lets a halted unit execute writes the accumulator or toggles the interrupt enable after a stop.

// File: rtl/accum_io_pkg.sv
package accum_io_pkg;
    localparam int IR_W = 12;
    localparam int IO_N = 6;

    // register group bit positions (decoded by the instruction format)
    localparam int RB_CLR_ACC  = 11;
    localparam int RB_CLR_LNK  = 10;
    localparam int RB_INV_ACC  = 9;
    localparam int RB_INV_LNK  = 8;
    localparam int RB_ROR      = 7;
    localparam int RB_ROL      = 6;
    localparam int RB_INC_ACC  = 5;
    localparam int RB_SK_POS   = 4;
    localparam int RB_SK_NEG   = 3;
    localparam int RB_SK_ZERO  = 2;
    localparam int RB_SK_LNK0  = 1;
    localparam int RB_STOP     = 0;

    // device group positions within the top IO_N instruction bits
    localparam int IB_RD       = 5;
    localparam int IB_WR       = 4;
    localparam int IB_SK_IN    = 3;
    localparam int IB_SK_OUT   = 2;
    localparam int IB_INT_ON   = 1;
    localparam int IB_INT_OFF  = 0;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } run_state_t;
endpackage

// File: rtl/accum_io_regops.sv
module accum_io_regops
    import accum_io_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [IR_W-1:0]   ops,
    input  logic [DATA_W-1:0] acc_in,
    input  logic              lnk_in,
    output logic [DATA_W-1:0] acc_res,
    output logic              lnk_res,
    output logic              acc_touch,
    output logic              lnk_touch,
    output logic              skip,
    output logic              stop_req
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] acc_w;
    logic              lnk_w;
    logic              lnk_tmp;

    always_comb begin
        acc_w   = acc_in;
        lnk_w   = lnk_in;
        lnk_tmp = 1'b0;
        if (ops[RB_CLR_ACC]) acc_w = '0;
        if (ops[RB_CLR_LNK]) lnk_w = 1'b0;
        if (ops[RB_INV_ACC]) acc_w = ~acc_w;
        if (ops[RB_INV_LNK]) lnk_w = ~lnk_w;
        if (ops[RB_ROR]) begin
            lnk_tmp = acc_w[0];
            acc_w   = {lnk_w, acc_w[MSB:1]};
            lnk_w   = lnk_tmp;
        end
        if (ops[RB_ROL]) begin
            lnk_tmp = acc_w[MSB];
            acc_w   = {acc_w[MSB-1:0], lnk_w};
            lnk_w   = lnk_tmp;
        end
        if (ops[RB_INC_ACC]) acc_w = acc_w + 1'b1;
        acc_res = acc_w;
        lnk_res = lnk_w;
    end

    assign acc_touch = ops[RB_CLR_ACC] | ops[RB_INV_ACC] | ops[RB_ROR]
                     | ops[RB_ROL] | ops[RB_INC_ACC];
    assign lnk_touch = ops[RB_CLR_LNK] | ops[RB_INV_LNK] | ops[RB_ROR]
                     | ops[RB_ROL];

    // skip conditions on pre-step values, collapsed to one pulse
    logic [3:0] sk_sel;
    logic [3:0] sk_cond;
    assign sk_sel  = {ops[RB_SK_POS], ops[RB_SK_NEG], ops[RB_SK_ZERO], ops[RB_SK_LNK0]};
    assign sk_cond = {~acc_in[MSB], acc_in[MSB], (acc_in == '0), ~lnk_in};
    assign skip     = |(sk_sel & sk_cond);
    assign stop_req = ops[RB_STOP];
endmodule

// File: rtl/accum_io_devport.sv
module accum_io_devport
    import accum_io_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IO_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IO_N-1:0]   ops,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [IO_W-1:0]   dev_in_data,
    input  logic              dev_in_stb,
    input  logic              dev_out_ack,
    output logic [DATA_W-1:0] acc_res,
    output logic              acc_touch,
    output logic              skip,
    output logic [IO_W-1:0]   out_buf,
    output logic              in_rdy,
    output logic              out_rdy,
    output logic              ien
);
    logic [IO_W-1:0] in_buf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_buf  <= '0;
            out_buf <= '0;
            in_rdy  <= 1'b0;
            out_rdy <= 1'b0;
            ien     <= 1'b0;
        end else begin
            if (dev_in_stb)       in_buf <= dev_in_data;
            if (dev_in_stb)       in_rdy <= 1'b1;
            else if (ops[IB_RD])  in_rdy <= 1'b0;
            if (ops[IB_WR])       out_buf <= acc_in[IO_W-1:0];
            if (dev_out_ack)      out_rdy <= 1'b1;
            else if (ops[IB_WR])  out_rdy <= 1'b0;
            if (ops[IB_INT_OFF])     ien <= 1'b0;
            else if (ops[IB_INT_ON]) ien <= 1'b1;
        end
    end

    generate
        if (DATA_W > IO_W) begin : g_wide
            assign acc_res = ops[IB_RD] ? {acc_in[DATA_W-1:IO_W], in_buf} : acc_in;
        end else begin : g_narrow
            assign acc_res = ops[IB_RD] ? in_buf[DATA_W-1:0] : acc_in;
        end
    endgenerate

    assign acc_touch = ops[IB_RD];
    assign skip      = (ops[IB_SK_IN] & in_rdy) | (ops[IB_SK_OUT] & out_rdy);
endmodule

// File: rtl/accum_io_runctl.sv
module accum_io_runctl
    import accum_io_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    output logic running
);
    run_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (stop_req) state_d = ST_HALT;
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  running = 1'b1;
            ST_HALT: running = 1'b0;
            default: running = 1'b0;
        endcase
    end
endmodule

// File: rtl/accum_io_exec.sv
module accum_io_exec
    import accum_io_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IO_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_en,
    input  logic              io_group,
    input  logic [IR_W-1:0]   ir_bits,
    input  logic [DATA_W-1:0] ac_in,
    input  logic              e_in,
    input  logic [IO_W-1:0]   dev_in_data,
    input  logic              dev_in_stb,
    input  logic              dev_out_ack,
    output logic [DATA_W-1:0] ac_out,
    output logic              ac_we,
    output logic              e_out,
    output logic              e_we,
    output logic              pc_inc,
    output logic              sc_clr,
    output logic [IO_W-1:0]   out_data,
    output logic              in_ready,
    output logic              out_ready,
    output logic              int_en,
    output logic              running
);
    logic              act;
    logic [IR_W-1:0]   reg_ops;
    logic [IO_N-1:0]   dev_ops;
    logic [DATA_W-1:0] acc_r, acc_d;
    logic              lnk_r;
    logic              acc_t_r, acc_t_d, lnk_t_r;
    logic              skip_r, skip_d, stop_req;

    assign act     = exec_en & running;
    assign reg_ops = (act & ~io_group) ? ir_bits : '0;
    assign dev_ops = (act &  io_group) ? ir_bits[IR_W-1 -: IO_N] : '0;

    accum_io_regops #(.DATA_W(DATA_W)) u_regops (
        .ops       (reg_ops),
        .acc_in    (ac_in),
        .lnk_in    (e_in),
        .acc_res   (acc_r),
        .lnk_res   (lnk_r),
        .acc_touch (acc_t_r),
        .lnk_touch (lnk_t_r),
        .skip      (skip_r),
        .stop_req  (stop_req)
    );

    accum_io_devport #(.DATA_W(DATA_W), .IO_W(IO_W)) u_devport (
        .clk         (clk),
        .rst_n       (rst_n),
        .ops         (dev_ops),
        .acc_in      (ac_in),
        .dev_in_data (dev_in_data),
        .dev_in_stb  (dev_in_stb),
        .dev_out_ack (dev_out_ack),
        .acc_res     (acc_d),
        .acc_touch   (acc_t_d),
        .skip        (skip_d),
        .out_buf     (out_data),
        .in_rdy      (in_ready),
        .out_rdy     (out_ready),
        .ien         (int_en)
    );

    accum_io_runctl u_runctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_req (stop_req),
        .running  (running)
    );

    assign ac_out = io_group ? acc_d : acc_r;
    assign ac_we  = acc_t_r | acc_t_d;
    assign e_out  = lnk_r;
    assign e_we   = lnk_t_r;
    assign pc_inc = skip_r | skip_d;
    assign sc_clr = act;
endmodule

// File: rtl/accum_io_exec_chk.sv
module accum_io_exec_chk (
    input logic clk,
    input logic rst_n,
    input logic exec_en,
    input logic io_group,
    input logic stop_bit,
    input logic rd_bit,
    input logic off_bit,
    input logic dev_in_stb,
    input logic dev_out_ack,
    input logic ac_we,
    input logic e_we,
    input logic pc_inc,
    input logic sc_clr,
    input logic in_ready,
    input logic out_ready,
    input logic int_en,
    input logic running
);
    assert_step_clears_seq_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && running) |-> sc_clr);

    assert_halt_inert_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!sc_clr && !ac_we && !e_we && !pc_inc));

    assert_stop_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && running && !io_group && stop_bit) |=> !running);

    assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> !running);

    assert_read_clears_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && running && io_group && rd_bit && !dev_in_stb) |=> !in_ready);

    assert_int_off_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && running && io_group && off_bit) |=> !int_en);

    assert_strobe_sets_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dev_in_stb |=> in_ready);

    assert_ack_sets_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dev_out_ack |=> out_ready);
endmodule

bind accum_io_exec accum_io_exec_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .exec_en     (exec_en),
    .io_group    (io_group),
    .stop_bit    (ir_bits[0]),
    .rd_bit      (ir_bits[11]),
    .off_bit     (ir_bits[6]),
    .dev_in_stb  (dev_in_stb),
    .dev_out_ack (dev_out_ack),
    .ac_we       (ac_we),
    .e_we        (e_we),
    .pc_inc      (pc_inc),
    .sc_clr      (sc_clr),
    .in_ready    (in_ready),
    .out_ready   (out_ready),
    .int_en      (int_en),
    .running     (running)
);

// File: tb/tb_accum_io_exec.sv
`timescale 1ns/1ps
module tb_accum_io_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_en = 1'b0;
    logic        io_group = 1'b0;
    logic [11:0] ir_bits = '0;
    logic [15:0] ac_in = '0;
    logic        e_in = 1'b0;
    logic [7:0]  dev_in_data = '0;
    logic        dev_in_stb = 1'b0;
    logic        dev_out_ack = 1'b0;
    logic [15:0] ac_out;
    logic        ac_we, e_out, e_we, pc_inc, sc_clr;
    logic [7:0]  out_data;
    logic        in_ready, out_ready, int_en, running;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    accum_io_exec dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=timeout expected=done");
            finish_run();
        end
    end

    // drive at a falling edge, settle 1ns
    task automatic drive(input logic en, input logic io, input logic [11:0] b,
                         input logic [15:0] a, input logic e);
        @(negedge clk);
        exec_en = en; io_group = io; ir_bits = b; ac_in = a; e_in = e;
        dev_in_stb = 1'b0; dev_out_ack = 1'b0;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        exec_en = 1'b0; ir_bits = '0; dev_in_stb = 1'b0; dev_out_ack = 1'b0;
        #1;
    endtask

    // expected register-group result {skip, link, acc}
    function automatic logic [17:0] rr_model(input logic [11:0] b, input logic [15:0] a0,
                                             input logic e0);
        logic [15:0] a;
        logic e, t, sk;
        a = a0; e = e0;
        if (b[11]) a = 16'h0000;
        if (b[10]) e = 1'b0;
        if (b[9])  a = ~a;
        if (b[8])  e = ~e;
        if (b[7]) begin t = a[0];  a = {e, a[15:1]}; e = t; end
        if (b[6]) begin t = a[15]; a = {a[14:0], e}; e = t; end
        if (b[5])  a = a + 16'd1;
        sk = (b[4] & ~a0[15]) | (b[3] & a0[15]) | (b[2] & (a0 == 16'h0)) | (b[1] & ~e0);
        return {sk, e, a};
    endfunction

    initial begin
        logic [15:0] avals [5];
        avals[0] = 16'h0000; avals[1] = 16'h8001; avals[2] = 16'h7FFE;
        avals[3] = 16'hFFFF; avals[4] = 16'h4C3A;

        #12;
        rst_n = 1'b1;
        idle();
        // R12 reset state
        chk("R12", running, 1, "running");
        chk("R12", in_ready, 0, "in_ready");
        chk("R12", out_ready, 0, "out_ready");
        chk("R12", int_en, 0, "int_en");
        chk("R12", out_data, 0, "out_data");
        chk("R13", sc_clr, 0, "sc_clr idle");

        // register group sweep over bits 11..1
        for (int m = 0; m < 2048; m++) begin
            for (int ai = 0; ai < 5; ai++) begin
                for (int ei = 0; ei < 2; ei++) begin
                    logic [11:0] b;
                    logic [17:0] ex;
                    logic [31:0] got, want;
                    string tag;
                    b = {m[10:0], 1'b0};
                    ex = rr_model(b, avals[ai], ei[0]);
                    drive(1'b1, 1'b0, b, avals[ai], ei[0]);
                    if (b == 0) tag = "R13";
                    else if ($countones(b) > 1) tag = "R4";
                    else if (b[7] | b[6]) tag = "R3";
                    else if (b[4] | b[3] | b[2] | b[1]) tag = "R5";
                    else tag = "R2";
                    got  = {10'd0, sc_clr, ac_we, e_we, pc_inc, e_out, (b[11]|b[9]|b[7]|b[6]|b[5]) ? ac_out : avals[ai]};
                    want = {10'd0, 1'b1, (b[11]|b[9]|b[7]|b[6]|b[5]), (b[10]|b[8]|b[7]|b[6]),
                            ex[17], ex[16], ex[15:0]};
                    if (!(b[10]|b[8]|b[7]|b[6])) want[16] = e_out;
                    chk(tag, got, want, $sformatf("reg bits=%h ac=%h e=%0d", b, avals[ai], ei));
                    if (b == 0) chk("R13", ac_out, avals[ai], "pass-through acc");
                end
            end
        end
        idle();

        // R13: exec_en low with bits set does nothing
        drive(1'b0, 1'b0, 12'hFFE, 16'h1234, 1'b1);
        chk("R13", {ac_we, e_we, pc_inc, sc_clr}, 0, "disabled step");
        chk("R1", sc_clr, 0, "no step no clear");

        // device input: strobe loads buffer (R11)
        @(negedge clk); dev_in_data = 8'hA5; dev_in_stb = 1'b1;
        idle();
        chk("R11", in_ready, 1, "in_ready after strobe");
        drive(1'b1, 1'b1, 12'h200, 16'h0, 1'b0);
        chk("R9", pc_inc, 1, "skip on input ready");
        chk("R1", sc_clr, 1, "device step clears counter");
        drive(1'b1, 1'b1, 12'h100, 16'h0, 1'b0);
        chk("R9", pc_inc, 0, "no skip output not ready");
        drive(1'b1, 1'b1, 12'h800, 16'h1234, 1'b0);
        chk("R7", ac_out, 16'h12A5, "read input into low byte");
        chk("R7", ac_we, 1, "ac_we on read");
        idle();
        chk("R7", in_ready, 0, "in_ready cleared by read");
        drive(1'b1, 1'b1, 12'h200, 16'h0, 1'b0);
        chk("R9", pc_inc, 0, "no skip after read");

        // strobe wins over same-cycle clear
        @(negedge clk); exec_en = 1'b0; dev_in_data = 8'h3C; dev_in_stb = 1'b1;
        @(negedge clk); dev_in_stb = 1'b0;
        exec_en = 1'b1; io_group = 1'b1; ir_bits = 12'h800; ac_in = 16'hFF00;
        dev_in_data = 8'h5A; dev_in_stb = 1'b1; #1;
        chk("R7", ac_out, 16'hFF3C, "read uses pre-step buffer");
        idle();
        chk("R11", in_ready, 1, "strobe beats clear");

        // output path
        @(negedge clk); dev_out_ack = 1'b1;
        idle();
        chk("R11", out_ready, 1, "out_ready after ack");
        drive(1'b1, 1'b1, 12'h100, 16'h0, 1'b0);
        chk("R9", pc_inc, 1, "skip on output ready");
        drive(1'b1, 1'b1, 12'h400, 16'hBEEF, 1'b0);
        chk("R8", ac_we, 0, "write-out leaves acc");
        idle();
        chk("R8", out_data, 8'hEF, "output buffer loaded");
        chk("R8", out_ready, 0, "out_ready cleared");
        @(negedge clk);
        exec_en = 1'b1; io_group = 1'b1; ir_bits = 12'h400; ac_in = 16'h0077; dev_out_ack = 1'b1;
        idle();
        chk("R11", out_ready, 1, "ack beats clear");
        chk("R8", out_data, 8'h77, "second output");

        // read and write together: output gets old acc (buffer holds 5A)
        drive(1'b1, 1'b1, 12'hC00, 16'h00C3, 1'b0);
        chk("R8", ac_out, 16'h005A, "combined read value");
        idle();
        chk("R8", out_data, 8'hC3, "combined write uses old acc");

        // interrupt enable
        drive(1'b1, 1'b1, 12'h080, 16'h0, 1'b0); idle();
        chk("R10", int_en, 1, "int on");
        drive(1'b1, 1'b1, 12'h040, 16'h0, 1'b0); idle();
        chk("R10", int_en, 0, "int off");
        drive(1'b1, 1'b1, 12'h080, 16'h0, 1'b0); idle();
        drive(1'b1, 1'b1, 12'h0C0, 16'h0, 1'b0); idle();
        chk("R10", int_en, 0, "on+off ends off");

        // halt
        drive(1'b1, 1'b0, 12'h801, 16'h5555, 1'b0);
        chk("R6", ac_out, 16'h0000, "ops apply in stop step");
        chk("R1", sc_clr, 1, "stop step clears counter");
        idle();
        chk("R6", running, 0, "halted");
        drive(1'b1, 1'b1, 12'h080, 16'h1111, 1'b0);
        chk("R6", {ac_we, e_we, pc_inc, sc_clr}, 0, "halted step inert");
        idle();
        chk("R6", int_en, 0, "halted no int change");
        drive(1'b1, 1'b0, 12'h820, 16'h1111, 1'b1);
        chk("R6", {ac_we, e_we, pc_inc, sc_clr}, 0, "halted reg step inert");
        idle(); idle();
        chk("R6", running, 0, "halt sticky");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        idle();
        chk("R12", running, 1, "reset resumes run");
        chk("R12", out_data, 0, "reset clears output");

        finish_run();
    end
endmodule